// File: doc/BRIEF.md
# PWM Emergency Shutdown Controller

This block sits between the channel waveform generators and the output pads of an eight-channel PWM unit. It watches an external trip pin that shares the pad of the highest-numbered channel. When the shutdown feature is armed and the trip pin reaches its programmed active polarity, every enabled channel is forced to a programmed safe level. Otherwise the enabled channels pass their waveform through unchanged.

Arming the feature turns the shared pad into an input. The block lowers that pad's output enable and never lets the last channel's own waveform reach the pad. The trip pin is resynchronised by a two-flop chain. The override and the status bit both work from the synchronised value, so they follow the pad two clock edges late when it is asserted and again when it is released. Disabled channels always rest at their idle level, which is 0.

Top module: `pwm_shutdown_ctrl`

## Requirements
- R1: `trip_pad_oe_o` is 0 while `sd_enable_i` is 1, and 1 while `sd_enable_i` is 0.
- R2: `trip_status_o` equals the value `trip_pin_i` had before the second-most-recent rising clock edge, whether or not `sd_enable_i` is set.
- R3: With `sd_enable_i` = 1, a trip exists when the synchronised pin equals `trip_polarity_i` (0 = active low, 1 = active high). During a trip, every enabled channel below the last one outputs `safe_level_i`.
- R4: `safe_level_i` = 0 forces tripped channels low and `safe_level_i` = 1 forces them high. A change of `safe_level_i` during a trip shows on the outputs in the same cycle.
- R5: A channel whose enable bit is 0 outputs 0 in all modes.
- R6: With `sd_enable_i` = 0, each enabled channel outputs its waveform, and `trip_polarity_i`, `safe_level_i` and the pin level have no effect on `pwm_o`.
- R7: With `sd_enable_i` = 1, `pwm_o[NCH-1]` (bit 7 by default) is 0 whatever its waveform and enable are.
- R8: The override appears after the second rising edge that follows the pin reaching its active level. It is released after the second rising edge that follows the pin returning to its inactive level.
- R9: While `rst_n` is low, the synchroniser holds 0, so `trip_status_o` reads 0 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trip_pin_i | input | 1 | Raw level of the shared trip pad |
| chan_wave_i | input | NCH | Per-channel PWM waveforms |
| chan_en_i | input | NCH | Per-channel enables |
| sd_enable_i | input | 1 | Arms emergency shutdown and turns the shared pad into an input |
| trip_polarity_i | input | 1 | Active pin level: 0 low, 1 high |
| safe_level_i | input | 1 | Level forced onto tripped channels |
| pwm_o | output | NCH | Final channel outputs |
| trip_pad_oe_o | output | 1 | Output enable for the shared pad |
| trip_status_o | output | 1 | Synchronised pin level |

## Verification
The bench counts the two-edge latency on both assertion and release of the trip. A design that compared the raw pin, or added a third stage, would move the override one cycle early or late. It changes the polarity and safe level while the feature is disarmed, which catches a design that lets either leak into the outputs. It also enables and trips the last channel, which exposes a design that forces the shared pad to the safe level instead of keeping it quiet. Disabled channels are checked during a trip with safe level 1, since a design that overrides them would drive them high.

// File: rtl/pwm_sd_pkg.sv
package pwm_sd_pkg;
  typedef struct packed {
    logic armed;
    logic trip_high;
    logic safe_level;
  } sd_ctrl_t;
endpackage

// File: rtl/pwm_sd_sync.sv
module pwm_sd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pwm_sd_detect.sv
module pwm_sd_detect
  import pwm_sd_pkg::*;
(
  input  sd_ctrl_t ctrl_i,
  input  logic     pin_sync_i,
  output logic     trip_o,
  output logic     pad_oe_o
);
  always_comb begin
    trip_o   = ctrl_i.armed & (pin_sync_i == ctrl_i.trip_high);
    pad_oe_o = ~ctrl_i.armed;
  end
endmodule

// File: rtl/pwm_sd_outmux.sv
module pwm_sd_outmux
  import pwm_sd_pkg::*;
#(
  parameter int NCH = 8
) (
  input  sd_ctrl_t         ctrl_i,
  input  logic             trip_i,
  input  logic [NCH-1:0]   wave_i,
  input  logic [NCH-1:0]   en_i,
  output logic [NCH-1:0]   out_o
);
  localparam int SHARED = NCH - 1;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    if (ch == SHARED) begin : g_shared
      always_comb begin
        if (!en_i[ch] || ctrl_i.armed) out_o[ch] = 1'b0;
        else                           out_o[ch] = wave_i[ch];
      end
    end else begin : g_plain
      always_comb begin
        if (!en_i[ch])   out_o[ch] = 1'b0;
        else if (trip_i) out_o[ch] = ctrl_i.safe_level;
        else             out_o[ch] = wave_i[ch];
      end
    end
  end
endmodule

// File: rtl/pwm_shutdown_ctrl.sv
module pwm_shutdown_ctrl
  import pwm_sd_pkg::*;
#(
  parameter int NCH         = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           trip_pin_i,
  input  logic [NCH-1:0] chan_wave_i,
  input  logic [NCH-1:0] chan_en_i,
  input  logic           sd_enable_i,
  input  logic           trip_polarity_i,
  input  logic           safe_level_i,
  output logic [NCH-1:0] pwm_o,
  output logic           trip_pad_oe_o,
  output logic           trip_status_o
);
  sd_ctrl_t ctrl;
  logic     pin_sync;
  logic     trip;

  always_comb begin
    ctrl.armed      = sd_enable_i;
    ctrl.trip_high  = trip_polarity_i;
    ctrl.safe_level = safe_level_i;
  end

  pwm_sd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (trip_pin_i),
    .q_o   (pin_sync)
  );

  pwm_sd_detect u_detect (
    .ctrl_i     (ctrl),
    .pin_sync_i (pin_sync),
    .trip_o     (trip),
    .pad_oe_o   (trip_pad_oe_o)
  );

  pwm_sd_outmux #(.NCH(NCH)) u_mux (
    .ctrl_i (ctrl),
    .trip_i (trip),
    .wave_i (chan_wave_i),
    .en_i   (chan_en_i),
    .out_o  (pwm_o)
  );

  assign trip_status_o = pin_sync;
endmodule

// File: rtl/pwm_sd_checker.sv
module pwm_sd_checker #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           trip_pin_i,
  input logic [NCH-1:0] chan_wave_i,
  input logic [NCH-1:0] chan_en_i,
  input logic           sd_enable_i,
  input logic           trip_polarity_i,
  input logic           safe_level_i,
  input logic [NCH-1:0] pwm_o,
  input logic           trip_pad_oe_o,
  input logic           trip_status_o
);
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  assert_pad_input_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sd_enable_i |-> !trip_pad_oe_o);

  assert_status_lag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2) |-> (trip_status_o == $past(trip_pin_i, 2)));

  assert_shared_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sd_enable_i |-> !pwm_o[NCH-1]);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
    assert_disabled_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en_i[ch] |-> !pwm_o[ch]);
    assert_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!sd_enable_i && chan_en_i[ch]) |-> (pwm_o[ch] == chan_wave_i[ch]));
    if (ch < NCH - 1) begin : g_low
      assert_trip_force_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_enable_i && chan_en_i[ch] && (trip_status_o == trip_polarity_i))
          |-> (pwm_o[ch] == safe_level_i));
    end
  end
endmodule

bind pwm_shutdown_ctrl pwm_sd_checker #(.NCH(NCH)) u_sd_checker (
  .clk             (clk),
  .rst_n           (rst_n),
  .trip_pin_i      (trip_pin_i),
  .chan_wave_i     (chan_wave_i),
  .chan_en_i       (chan_en_i),
  .sd_enable_i     (sd_enable_i),
  .trip_polarity_i (trip_polarity_i),
  .safe_level_i    (safe_level_i),
  .pwm_o           (pwm_o),
  .trip_pad_oe_o   (trip_pad_oe_o),
  .trip_status_o   (trip_status_o)
);

// File: tb/tb_pwm_shutdown_ctrl.sv
module tb_pwm_shutdown_ctrl;
  localparam int NCH = 8;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           pin;
  logic [NCH-1:0] wave, en;
  logic           sd, pol, safe;
  logic [NCH-1:0] pwm;
  logic           oe, st;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  pwm_shutdown_ctrl #(.NCH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .trip_pin_i(pin), .chan_wave_i(wave),
    .chan_en_i(en), .sd_enable_i(sd), .trip_polarity_i(pol),
    .safe_level_i(safe), .pwm_o(pwm), .trip_pad_oe_o(oe), .trip_status_o(st)
  );

  // {en, wave, sd, pol, safe, pin, exp_pwm, exp_oe, exp_st}
  localparam logic [29:0] VEC [9] = '{
    {8'hFF, 8'hA5, 1'b0, 1'b1, 1'b1, 1'b1, 8'hA5, 1'b1, 1'b1}, // R6 bypass
    {8'hFF, 8'hA5, 1'b1, 1'b1, 1'b1, 1'b0, 8'h25, 1'b0, 1'b0}, // R3 no trip, R7
    {8'hFF, 8'hA5, 1'b1, 1'b1, 1'b1, 1'b1, 8'h7F, 1'b0, 1'b1}, // R3 high trip, R4
    {8'hFF, 8'hA5, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1}, // R4 safe low
    {8'h0F, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b0, 8'h0F, 1'b0, 1'b0}, // R3 low trip, R5
    {8'hF0, 8'h3C, 1'b1, 1'b0, 1'b1, 1'b1, 8'h30, 1'b0, 1'b1}, // R5 R7 no trip
    {8'h55, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b0, 8'h55, 1'b1, 1'b0}, // R6 R2 disarmed
    {8'h80, 8'h80, 1'b0, 1'b1, 1'b0, 1'b0, 8'h80, 1'b1, 1'b0}, // R1 shared pad out
    {8'h80, 8'h80, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0}  // R7 shared quiet
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  initial begin
    rst_n = 1'b0; pin = 1'b1; wave = '0; en = '0; sd = 1'b0; pol = 1'b0; safe = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 status in reset", 32'(st), 32'h0);
    chk("R1 oe in reset", 32'(oe), 32'h1);
    rst_n = 1'b1;

    for (int i = 0; i < 9; i++) begin
      {en, wave, sd, pol, safe, pin} = VEC[i][29:10];
      repeat (3) @(negedge clk);
      chk($sformatf("R3/R6 vec %0d pwm", i), 32'(pwm), 32'(VEC[i][9:2]));
      chk($sformatf("R1 vec %0d oe", i), 32'(oe), 32'(VEC[i][1]));
      chk($sformatf("R2 vec %0d status", i), 32'(st), 32'(VEC[i][0]));
    end

    // R8: latency of assertion and release
    en = 8'hFF; wave = 8'h00; sd = 1'b1; pol = 1'b1; safe = 1'b1; pin = 1'b0;
    repeat (3) @(negedge clk);
    pin = 1'b1;
    @(negedge clk);
    chk("R8 not yet tripped", 32'(pwm), 32'h00);
    @(negedge clk);
    chk("R8 tripped at 2nd edge", 32'(pwm), 32'h7F);
    // R4: safe level follows combinationally
    safe = 1'b0; #1;
    chk("R4 safe change same cycle", 32'(pwm), 32'h00);
    safe = 1'b1; #1;
    chk("R4 safe back high", 32'(pwm), 32'h7F);
    @(negedge clk);
    pin = 1'b0;
    @(negedge clk);
    chk("R8 still held after 1 edge", 32'(pwm), 32'h7F);
    @(negedge clk);
    chk("R8 released at 2nd edge", 32'(pwm), 32'h00);

    // R2: status tracks pin while disarmed, with the same lag
    sd = 1'b0; pin = 1'b1;
    @(negedge clk);
    chk("R2 status lag 1", 32'(st), 32'h0);
    @(negedge clk);
    chk("R2 status after 2", 32'(st), 32'h1);

    // R6: polarity/safe changes ignored while disarmed
    wave = 8'h3C; pol = 1'b1; safe = 1'b0;
    @(negedge clk);
    chk("R6 ignore pol/safe", 32'(pwm), 32'h3C);

    // R9: asynchronous reset clears status at once
    #3 rst_n = 1'b0; #1;
    chk("R9 async clear", 32'(st), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule